// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block collects level-sensitive interrupt lines and hands each of them to one or more of up to four processors. Software sees two register banks through one request port. The global bank holds a per-source enable bit and a per-source routing word that says which processors may take that source. The per-CPU bank holds a per-source mask bit for the processor that makes the access, plus an acknowledge register. Enables and masks are never written as bitmaps. Software writes a source index to a dedicated "set" or "clear" offset instead, so two processors never race on a read-modify-write.

Three source numbers belong to each processor rather than being shared. Sources 0 and 1 carry per-CPU summary lines from a doorbell unit: one for inter-processor messages and one for message-signalled interrupts. A third, configurable number (5 by default) carries each processor's private timer. Every other source is a shared input that reaches a processor only through its routing bit. Each processor has its own request output. Its acknowledge read returns the lowest-numbered deliverable source, or a spurious code when none is deliverable. Reading has no side effect: a line stays pending for as long as its device drives it high.

The request port has no back-pressure. A request is taken in the cycle in which `req_valid` is high. A read is answered in the next cycle with a one-cycle `rsp_valid` pulse, and a write produces no response.

Top module: `irqd_dist`

## Requirements
- R1: After reset every enable is clear, every per-CPU mask bit is set, every routing word equals 1 (CPU 0 only), and all `irq_out` bits are low.
- R2: A read of global offset 0x000 returns the number of sources in bits [11:2] and zero elsewhere.
- R3: Writing index n (taken from `req_wdata[9:0]`) to global offset 0x030 sets the enable of source n, and writing it to 0x034 clears that enable. An index of `NUM_SRC` or more changes nothing.
- R4: Writing index n to per-CPU offset 0x048 masks source n for the CPU named by `req_cpu`, and writing it to 0x04C unmasks it. The masks of other CPUs are left unchanged.
- R5: The routing word of source n is at global offset 0x100 + 4·n. Bits [NUM_CPU-1:0] are written from `req_wdata` and read back in the same bits, with zero above. Bit c permits delivery of a shared source to CPU c, and more than one bit may be set.
- R6: A shared source n is deliverable to CPU c only when `src_in[n]` is high, its enable is set, routing bit c is set and it is unmasked for CPU c.
- R7: A read of per-CPU offset 0x044 returns in bits [9:0] the lowest-numbered source deliverable to CPU `req_cpu`, or 1023 when none is deliverable. The read changes no state.
- R8: Source 0 for CPU c is `ipi_sum[c]` and source 1 is `msg_sum[c]`. Each is gated only by CPU c's mask and ignores enable and routing.
- R9: Source `TIMER_SRC` for CPU c is `ptimer[c]`, gated by the global enable and CPU c's mask. Routing is ignored for it.
- R10: `irq_out[c]` is high in exactly those cycles in which some source is deliverable to CPU c. It follows the inputs in the same cycle.
- R11: A read is answered one cycle after it is accepted, with a single-cycle `rsp_valid`. Writes give no response. Reads of unmapped offsets return 0.
- R12: Sources are level-sensitive. A deliverable source stays pending across acknowledge reads until its input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | 0 = global bank, 1 = per-CPU bank |
| req_cpu | input | CPU_W | Accessing CPU for per-CPU bank |
| req_addr | input | 12 | Byte offset within the bank |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_data | output | 32 | Read data |
| src_in | input | NUM_SRC | Shared interrupt lines, bits 0, 1 and TIMER_SRC unused |
| ipi_sum | input | NUM_CPU | Per-CPU inter-processor doorbell summary |
| msg_sum | input | NUM_CPU | Per-CPU message-signalled doorbell summary |
| ptimer | input | NUM_CPU | Per-CPU private timer lines |
| irq_out | output | NUM_CPU | Per-CPU interrupt request |

## Verification
The bench targets several specific failure modes. An enable index of 32 or more must be ignored: a design that truncated the index would set a low-numbered source instead, and the bench sees that source start to fire. Per-CPU sources are tested with routing left at CPU 0, so a design that applied routing to the doorbell or timer lines would leave other CPUs silent. A design that applied the enable to the doorbell lines would keep them off. The acknowledge value is compared when several sources are pending together, and again after the lowest one falls. A wrong priority direction, or an acknowledge read that cleared state, would return the wrong number or drop a line that is still high.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int ID_W   = 10;

  localparam logic [ADDR_W-1:0] OFF_CTRL     = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_EN_SET   = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR   = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_ACK      = 12'h044;
  localparam logic [ADDR_W-1:0] OFF_MASK_SET = 12'h048;
  localparam logic [ADDR_W-1:0] OFF_MASK_CLR = 12'h04C;
  localparam logic [3:0]        ROUTE_PAGE   = 4'h1;

  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  localparam logic BANK_GLOBAL = 1'b0;
  localparam logic BANK_CPU    = 1'b1;

  typedef struct packed {
    logic            en_set;
    logic            en_clr;
    logic            msk_set;
    logic            msk_clr;
    logic            route_wr;
    logic            rd_ctrl;
    logic            rd_ack;
    logic            rd_route;
    logic [ID_W-1:0] wr_idx;
    logic [5:0]      route_idx;
  } dec_t;
endpackage

// File: rtl/irqd_decode.sv
module irqd_decode
  import irqd_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_idx,
  output dec_t              dec
);
  logic in_route;

  always_comb begin
    in_route = (req_addr[11:8] == ROUTE_PAGE) && (req_addr[1:0] == 2'b00) &&
               ({1'b0, req_addr[7:2]} < 7'(NUM_SRC));
  end

  always_comb begin
    dec           = '0;
    dec.wr_idx    = req_idx;
    dec.route_idx = req_addr[7:2];
    if (req_valid) begin
      if (req_bank == BANK_GLOBAL) begin
        if (req_write) begin
          dec.en_set   = (req_addr == OFF_EN_SET);
          dec.en_clr   = (req_addr == OFF_EN_CLR);
          dec.route_wr = in_route;
        end else begin
          dec.rd_ctrl  = (req_addr == OFF_CTRL);
          dec.rd_route = in_route;
        end
      end else begin
        if (req_write) begin
          dec.msk_set = (req_addr == OFF_MASK_SET);
          dec.msk_clr = (req_addr == OFF_MASK_CLR);
        end else begin
          dec.rd_ack  = (req_addr == OFF_ACK);
        end
      end
    end
  end
endmodule

// File: rtl/irqd_state.sv
module irqd_state
  import irqd_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dec_t               dec,
  input  logic [CPU_W-1:0]   req_cpu,
  input  logic [NUM_CPU-1:0] route_wdata,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_CPU-1:0] route_q [NUM_SRC],
  output logic [NUM_SRC-1:0] msk_q   [NUM_CPU]
);
  localparam logic [NUM_CPU-1:0] ROUTE_RST = NUM_CPU'(1);

  // Global enables: index-addressed set/clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (dec.en_set && dec.wr_idx == ID_W'(s)) en_q[s] <= 1'b1;
        else if (dec.en_clr && dec.wr_idx == ID_W'(s)) en_q[s] <= 1'b0;
      end
    end
  end

  // Routing words
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SRC; s++) route_q[s] <= ROUTE_RST;
    end else begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (dec.route_wr && dec.route_idx == 6'(s)) route_q[s] <= route_wdata;
      end
    end
  end

  // Per-CPU masks, one register row per processor
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_mask
    logic hit_cpu;
    always_comb hit_cpu = (req_cpu == CPU_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        msk_q[c] <= '1;
      end else if (hit_cpu) begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (dec.msk_set && dec.wr_idx == ID_W'(s)) msk_q[c][s] <= 1'b1;
          else if (dec.msk_clr && dec.wr_idx == ID_W'(s)) msk_q[c][s] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/irqd_cpu_port.sv
module irqd_cpu_port
  import irqd_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int TIMER_SRC = 5
) (
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] route_col,
  input  logic [NUM_SRC-1:0] msk,
  input  logic               ipi,
  input  logic               msg,
  input  logic               tmr,
  output logic               irq,
  output logic [ID_W-1:0]    ack_id
);
  logic [NUM_SRC-1:0] pend;
  logic unused_bits;

  always_comb unused_bits = ^{src_in[1:0], src_in[TIMER_SRC], en[1:0],
                              route_col[1:0], route_col[TIMER_SRC]};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s == 0) begin : g_ipi
      always_comb pend[s] = ipi & ~msk[s];
    end else if (s == 1) begin : g_msg
      always_comb pend[s] = msg & ~msk[s];
    end else if (s == TIMER_SRC) begin : g_tmr
      always_comb pend[s] = tmr & en[s] & ~msk[s];
    end else begin : g_shared
      always_comb pend[s] = src_in[s] & en[s] & route_col[s] & ~msk[s];
    end
  end

  // Lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    ack_id = SPURIOUS_ID;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (pend[s]) ack_id = ID_W'(s);
    end
  end

  always_comb irq = |pend;
endmodule

// File: rtl/irqd_dist.sv
module irqd_dist
  import irqd_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_CPU   = 4,
  parameter int TIMER_SRC = 5,
  localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_bank,
  input  logic [CPU_W-1:0]   req_cpu,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_CPU-1:0] ipi_sum,
  input  logic [NUM_CPU-1:0] msg_sum,
  input  logic [NUM_CPU-1:0] ptimer,
  output logic [NUM_CPU-1:0] irq_out
);
  dec_t               dec;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_CPU-1:0] route_q [NUM_SRC];
  logic [NUM_SRC-1:0] msk_q   [NUM_CPU];
  logic [ID_W-1:0]    ack_ids [NUM_CPU];
  logic [DATA_W-1:0]  rd_next;
  logic               unused_wdata;

  always_comb unused_wdata = ^req_wdata[DATA_W-1:ID_W];

  irqd_decode #(.NUM_SRC(NUM_SRC)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_bank  (req_bank),
    .req_addr  (req_addr),
    .req_idx   (req_wdata[ID_W-1:0]),
    .dec       (dec)
  );

  irqd_state #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec         (dec),
    .req_cpu     (req_cpu),
    .route_wdata (req_wdata[NUM_CPU-1:0]),
    .en_q        (en_q),
    .route_q     (route_q),
    .msk_q       (msk_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] route_col;
    always_comb begin
      for (int s = 0; s < NUM_SRC; s++) route_col[s] = route_q[s][c];
    end

    irqd_cpu_port #(.NUM_SRC(NUM_SRC), .TIMER_SRC(TIMER_SRC)) u_port (
      .src_in    (src_in),
      .en        (en_q),
      .route_col (route_col),
      .msk       (msk_q[c]),
      .ipi       (ipi_sum[c]),
      .msg       (msg_sum[c]),
      .tmr       (ptimer[c]),
      .irq       (irq_out[c]),
      .ack_id    (ack_ids[c])
    );
  end

  // Read data selection
  always_comb begin
    rd_next = '0;
    if (dec.rd_ctrl) begin
      rd_next[ID_W+1:2] = ID_W'(NUM_SRC);
    end else if (dec.rd_ack) begin
      rd_next[ID_W-1:0] = ack_ids[req_cpu];
    end else if (dec.rd_route) begin
      rd_next[NUM_CPU-1:0] = route_q[dec.route_idx[SRC_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid & ~req_write;
      rsp_data  <= (req_valid & ~req_write) ? rd_next : '0;
    end
  end
endmodule

// File: rtl/irqd_dist_chk.sv
module irqd_dist_chk
  import irqd_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CPU  = 4,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic               req_bank,
  input logic [CPU_W-1:0]   req_cpu,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_data,
  input logic [NUM_CPU-1:0] irq_out
);
  logic rd_q, ack_q, ctrl_q, hit_q, unmask_seen;
  logic rd_now, ack_now, ctrl_now, unmask_now;
  localparam logic [DATA_W-1:0] CTRL_EXP = DATA_W'(NUM_SRC) << 2;

  always_comb begin
    rd_now     = req_valid & ~req_write;
    ack_now    = rd_now & (req_bank == BANK_CPU) & (req_addr == OFF_ACK);
    ctrl_now   = rd_now & (req_bank == BANK_GLOBAL) & (req_addr == OFF_CTRL);
    unmask_now = req_valid & req_write & (req_bank == BANK_CPU) &
                 (req_addr == OFF_MASK_CLR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b0; ack_q <= 1'b0; ctrl_q <= 1'b0; hit_q <= 1'b0;
      unmask_seen <= 1'b0;
    end else begin
      rd_q        <= rd_now;
      ack_q       <= ack_now;
      ctrl_q      <= ctrl_now;
      hit_q       <= irq_out[req_cpu];
      unmask_seen <= unmask_seen | unmask_now;
    end
  end

  AST_QUIET_UNTIL_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
    !unmask_seen |-> (irq_out == '0)); // R1
  AST_CTRL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ctrl_q) |-> (rsp_data == CTRL_EXP)); // R2
  AST_ACK_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ack_q && !hit_q) |-> (rsp_data == 32'd1023)); // R7
  AST_ACK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ack_q && hit_q) |-> (rsp_data < 32'(NUM_SRC))); // R7
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == rd_q); // R11
endmodule

bind irqd_dist irqd_dist_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_bank  (req_bank),
  .req_cpu   (req_cpu),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .irq_out   (irq_out)
);

// File: tb/irqd_dist_bench.sv
module irqd_dist_bench;
  localparam int NS  = 32;
  localparam int NC  = 4;
  localparam int TMR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_bank = 1'b0;
  logic [1:0]  req_cpu = '0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [NS-1:0] src = '0;
  logic [NC-1:0] ipi = '0, msg = '0, tmr = '0;
  logic [NC-1:0] irq_out;

  int n_chk = 0;
  int n_err = 0;

  bit          m_en  [NS];
  bit          m_msk [NC][NS];
  bit [NC-1:0] m_route [NS];

  always #4 clk = ~clk;

  irqd_dist u_irqd_dist (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_cpu(req_cpu), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .src_in(src), .ipi_sum(ipi), .msg_sum(msg), .ptimer(tmr), .irq_out(irq_out)
  );

  function automatic bit deliv(int c, int s);
    if (s == 0)   return ipi[c] && !m_msk[c][s];
    if (s == 1)   return msg[c] && !m_msk[c][s];
    if (s == TMR) return tmr[c] && m_en[s] && !m_msk[c][s];
    return src[s] && m_en[s] && m_route[s][c] && !m_msk[c][s];
  endfunction

  function automatic int exp_ack(int c);
    for (int s = 0; s < NS; s++) if (deliv(c, s)) return s;
    return 1023;
  endfunction

  function automatic bit [NC-1:0] exp_irq();
    bit [NC-1:0] v = '0;
    for (int c = 0; c < NC; c++) v[c] = (exp_ack(c) != 1023);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit bank, input int cpu, input logic [11:0] addr, input int data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_bank = bank;
    req_cpu = 2'(cpu); req_addr = addr; req_wdata = 32'(data);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (!bank) begin
      if (addr == 12'h030 && data < NS) m_en[data] = 1'b1;
      if (addr == 12'h034 && data < NS) m_en[data] = 1'b0;
      if (addr[11:8] == 4'h1 && addr[1:0] == 2'b00 && addr[7:2] < NS)
        m_route[addr[7:2]] = 4'(data);
    end else begin
      if (addr == 12'h048 && data < NS) m_msk[cpu][data] = 1'b1;
      if (addr == 12'h04C && data < NS) m_msk[cpu][data] = 1'b0;
    end
  endtask

  task automatic rd(input bit bank, input int cpu, input logic [11:0] addr, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_bank = bank;
    req_cpu = 2'(cpu); req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R11 rsp_valid", rsp_valid, 1);
    d = rsp_data;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    @(negedge clk);
    chk(irq_out === exp_irq(), {tag, " R10 irq_out"}, irq_out, exp_irq());
    for (int c = 0; c < NC; c++) begin
      rd(1'b1, c, 12'h044, d);
      chk(d == 32'(exp_ack(c)), {tag, " R7 ack"}, d, exp_ack(c));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int s = 0; s < NS; s++) begin
      m_en[s] = 1'b0; m_route[s] = 4'b0001;
      for (int c = 0; c < NC; c++) m_msk[c][s] = 1'b1;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(irq_out === 4'b0, "R1 irq after reset", irq_out, 0);
    rd(1'b0, 0, 12'h100 + 12'(4 * 7), d);
    chk(d == 32'd1, "R1 route reset", d, 1);
    // R2 control word
    rd(1'b0, 0, 12'h000, d);
    chk(d == 32'(NS << 2), "R2 ctrl", d, NS << 2);
    // R11 unmapped read
    rd(1'b0, 0, 12'h0F0, d);
    chk(d == 32'd0, "R11 unmapped", d, 0);
    check_all("R1");

    // R6 gating: input high but masked and disabled
    src[7] = 1'b1; src[9] = 1'b1;
    check_all("R6 masked");
    wr(1'b1, 0, 12'h04C, 7);
    wr(1'b1, 1, 12'h04C, 7);
    check_all("R6 disabled");
    wr(1'b0, 0, 12'h030, 7);
    @(negedge clk);
    chk(irq_out === 4'b0001, "R5 default route", irq_out, 1);
    check_all("R3 enable");
    // R5 routing change and read back
    wr(1'b0, 0, 12'h100 + 12'(4 * 7), 32'h0000_0012);
    rd(1'b0, 0, 12'h100 + 12'(4 * 7), d);
    chk(d == 32'h2, "R5 route readback", d, 2);
    @(negedge clk);
    chk(irq_out === 4'b0010, "R5 route cpu1", irq_out, 2);
    // R3 out-of-range index ignored (39 would alias 7 if truncated)
    wr(1'b0, 0, 12'h034, 7);
    wr(1'b0, 0, 12'h030, 39);
    @(negedge clk);
    chk(irq_out === 4'b0000, "R3 index out of range", irq_out, 0);
    // R4 mask isolation: masking on cpu0 leaves cpu1
    wr(1'b0, 0, 12'h030, 7);
    wr(1'b1, 0, 12'h048, 7);
    @(negedge clk);
    chk(irq_out[1] === 1'b1, "R4 other cpu mask kept", irq_out[1], 1);
    check_all("R4");

    // R8 doorbells ignore enable and routing
    ipi[2] = 1'b1;
    check_all("R8 masked");
    wr(1'b1, 2, 12'h04C, 0);
    wr(1'b1, 2, 12'h04C, 1);
    @(negedge clk);
    chk(irq_out[2] === 1'b1, "R8 ipi to cpu2", irq_out[2], 1);
    msg[2] = 1'b1;
    rd(1'b1, 2, 12'h044, d);
    chk(d == 32'd0, "R7 lowest wins", d, 0);
    rd(1'b1, 2, 12'h044, d);
    chk(d == 32'd0, "R12 ack no side effect", d, 0);
    ipi[2] = 1'b0;
    rd(1'b1, 2, 12'h044, d);
    chk(d == 32'd1, "R12 level follows input", d, 1);

    // R9 private timer: route of source 5 stays CPU 0
    tmr[3] = 1'b1; tmr[0] = 1'b1;
    wr(1'b1, 3, 12'h04C, TMR);
    @(negedge clk);
    chk(irq_out[3] === 1'b0, "R9 timer needs enable", irq_out[3], 0);
    wr(1'b0, 0, 12'h030, TMR);
    @(negedge clk);
    chk(irq_out[3] === 1'b1, "R9 timer cpu3", irq_out[3], 1);
    check_all("R9");
    tmr[3] = 1'b0;
    @(negedge clk);
    chk(irq_out[3] === 1'b0, "R12 timer drop", irq_out[3], 0);

    // Random mixed traffic against the model
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 8;
      int idx = $urandom % 36;
      int cpu = $urandom % NC;
      case (op)
        0: wr(1'b0, 0, 12'h030, idx);
        1: wr(1'b0, 0, 12'h034, idx);
        2: wr(1'b1, cpu, 12'h048, idx);
        3, 4: wr(1'b1, cpu, 12'h04C, idx);
        5: wr(1'b0, 0, 12'h100 + 12'(4 * (idx % NS)), $urandom % 16);
        default: begin
          @(negedge clk);
          src = $urandom; ipi = 4'($urandom); msg = 4'($urandom); tmr = 4'($urandom);
        end
      endcase
      if (it % 4 == 3) check_all("R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule